// File: doc/BRIEF.md
# Four-Channel Converter Serial Register Front End

This block is the digital side of a four-channel, 14-bit converter. A host writes 16-bit words through a three-wire serial port made of a select line, a serial clock and a data line. The top two bits of each word pick one of four staging registers, and the low 14 bits become that channel's new code. A shared, level-sensitive transfer input then copies all staging registers into the output registers together, so several channels can change on the same cycle. The four output codes are the block's main outputs.

The serial pins are sampled by the block's own clock. They are expected to be synchronous to it already, and each serial clock level must last at least one block clock. A strap input chooses whether a clear sets every register to zero or to the half-scale code. An asynchronous power-on reset sets everything to zero. A serial output passes the shifted data on one word plus one serial clock later, so several devices can be chained on one select line.

Top module: `quad_dac_regif`

## Requirements
- R1: A word is shifted in most significant bit first, one bit on each rising edge of `sclk` while `cs_n` is low. Bits [15:14] of the word are the channel address and bits [13:0] are the code.
- R2: Address 0 writes channel 0, 1 writes channel 1, 2 writes channel 2 and 3 writes channel 3. Only the addressed staging register changes.
- R3: If more than 16 bits are shifted in during one select period, only the last 16 bits shifted in form the word.
- R4: A staging register is written on the clock after `cs_n` rises. While `cs_n` is high, `sclk` edges do not move the shift register.
- R5: While `load_n` is low, each output code takes the value of its staging register one clock later. While `load_n` is high, the output codes hold.
- R6: While `clr_n` is low, every staging and output register is set to 0x0000 when `mid_sel` is 0 and to 0x2000 when `mid_sel` is 1. A clear wins over both a write from the select line and a transfer from `load_n`.
- R7: While `rst_n` is low, all registers are zero at once, independent of the clock, and `sdo` is 0.
- R8: A bit shifted in on rising `sclk` edge k is driven on `sdo` from the falling edge that follows rising edge k+16. A downstream device that samples on rising edges therefore sees the bit 17 edges later.
- R9: `sdo` changes only on a falling `sclk` edge while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all serial pins are sampled with it |
| rst_n | input | 1 | Asynchronous power-on reset, active low; sets all registers to zero |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n | input | 1 | Serial select, active low; its rising edge writes the staging register |
| sdi | input | 1 | Serial data in |
| load_n | input | 1 | Level-sensitive transfer from staging to output registers, active low |
| clr_n | input | 1 | Synchronous clear, active low |
| mid_sel | input | 1 | Clear value strap: 0 gives zero code, 1 gives half-scale |
| sdo | output | 1 | Serial data out for chaining |
| dac_code | output | 56 | Output codes; channel i sits in bits [14*i+13:14*i] |

## Verification
A bad shift-register bit first shows on `sdo`, 17 serial clocks after it was corrupted. Inside the block it stays hidden until the end of the frame writes it into a staging register. A wrong staging register changes no output until `load_n` goes low, and then the wrong code appears one clock later. For this reason the bench transfers after most writes, and it also runs with `load_n` held low. A missing clear or a wrong priority shows on every output code on the clock after the clear.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

   // clear fill selection taken from the strap input
   typedef enum logic {
      FILL_ZERO = 1'b0,
      FILL_MID  = 1'b1
   } fill_e;

   localparam int unsigned DEF_DATA_W = 14;
   localparam int unsigned DEF_ADDR_W = 2;
   // extra stage between the word and the chain output
   localparam int unsigned CHAIN_XTRA = 1;

endpackage

// File: rtl/qdac_shift.sv
module qdac_shift #(
   parameter int unsigned WORD_W  = 16,
   parameter int unsigned CHAIN_W = WORD_W + quad_dac_pkg::CHAIN_XTRA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   output logic [WORD_W-1:0] word,
   output logic              commit,
   output logic              sdo
);

   logic               sclk_q;
   logic               cs_q;
   logic [CHAIN_W-1:0] chain_q;
   logic               sdo_q;
   logic               rise;
   logic               fall;
   logic               active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs_n;
      end
   end

   always_comb begin
      active = ~cs_n;
      rise   = sclk & ~sclk_q;
      fall   = ~sclk & sclk_q;
      commit = cs_n & ~cs_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (active && rise) begin
         chain_q <= {chain_q[CHAIN_W-2:0], sdi};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo_q <= 1'b0;
      end else if (active && fall) begin
         sdo_q <= chain_q[CHAIN_W-1];
      end
   end

   assign word = chain_q[WORD_W-1:0];
   assign sdo  = sdo_q;

endmodule

// File: rtl/qdac_decode.sv
module qdac_decode #(
   parameter int unsigned ADDR_W = 2,
   localparam int unsigned NCH   = 1 << ADDR_W
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NCH-1:0]    hit
);

   for (genvar g = 0; g < NCH; g++) begin : g_hit
      assign hit[g] = en && (addr == ADDR_W'(g));
   end

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
   import quad_dac_pkg::*;
#(
   parameter int unsigned DATA_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  fill_e             fill,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_n,
   output logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] out_q
);

   localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

   logic [DATA_W-1:0] fill_code;

   always_comb begin
      fill_code = (fill == FILL_MID) ? MID_CODE : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (!clr_n) begin
         stage_q <= fill_code;
      end else if (wr_en) begin
         stage_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (!clr_n) begin
         out_q <= fill_code;
      end else if (!load_n) begin
         out_q <= stage_q;
      end
   end

endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
   import quad_dac_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned ADDR_W = DEF_ADDR_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             sclk,
   input  logic                             cs_n,
   input  logic                             sdi,
   input  logic                             load_n,
   input  logic                             clr_n,
   input  logic                             mid_sel,
   output logic                             sdo,
   output logic [(1<<ADDR_W)*DATA_W-1:0]    dac_code
);

   localparam int unsigned NCH    = 1 << ADDR_W;
   localparam int unsigned WORD_W = ADDR_W + DATA_W;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("quad_dac_regif: DATA_W must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 4) begin : g_bad_addr_w
      $error("quad_dac_regif: ADDR_W must lie in 1..4");
   end

   logic [WORD_W-1:0]     word;
   logic                  commit;
   logic [NCH-1:0]        wr_hit;
   logic [NCH*DATA_W-1:0] in_flat;
   fill_e                 fill;

   assign fill = fill_e'(mid_sel);

   qdac_shift #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk   (sclk),
      .cs_n   (cs_n),
      .sdi    (sdi),
      .word   (word),
      .commit (commit),
      .sdo    (sdo)
   );

   qdac_decode #(
      .ADDR_W (ADDR_W)
   ) u_dec (
      .en   (commit),
      .addr (word[WORD_W-1 -: ADDR_W]),
      .hit  (wr_hit)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      qdac_chan #(
         .DATA_W (DATA_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_n   (clr_n),
         .fill    (fill),
         .wr_en   (wr_hit[c]),
         .wr_data (word[DATA_W-1:0]),
         .load_n  (load_n),
         .stage_q (in_flat[c*DATA_W +: DATA_W]),
         .out_q   (dac_code[c*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/quad_dac_regif_chk.sv
module quad_dac_regif_chk #(
   parameter int unsigned DATA_W = 14,
   parameter int unsigned ADDR_W = 2,
   localparam int unsigned NCH   = 1 << ADDR_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sclk,
   input logic                  cs_n,
   input logic                  load_n,
   input logic                  clr_n,
   input logic                  mid_sel,
   input logic                  sdo,
   input logic [NCH*DATA_W-1:0] in_flat,
   input logic [NCH*DATA_W-1:0] dac_code
);

   localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

   function automatic logic [NCH*DATA_W-1:0] all_fill(input logic m);
      return m ? {NCH{MID}} : '0;
   endfunction

   // R6
   clr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (dac_code == all_fill($past(mid_sel)) &&
                  in_flat  == all_fill($past(mid_sel))));

   // R5
   follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !load_n) |=> (dac_code == $past(in_flat)));

   // R5
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n) |=> $stable(dac_code));

   // R4
   idle_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && cs_n && $past(cs_n)) |=> $stable(in_flat));

   // R9
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cs_n && $fell(sclk)) |=> $stable(sdo));

   // R7
   rst_zero_chk: assert property (@(posedge clk)
      !rst_n |-> (dac_code == '0 && in_flat == '0 && sdo == 1'b0));

endmodule

bind quad_dac_regif quad_dac_regif_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk     (sclk),
   .cs_n     (cs_n),
   .load_n   (load_n),
   .clr_n    (clr_n),
   .mid_sel  (mid_sel),
   .sdo      (sdo),
   .in_flat  (in_flat),
   .dac_code (dac_code)
);

// File: tb/test_quad_dac_regif.sv
`timescale 1ns/1ps
module test_quad_dac_regif;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        sdi = 1'b0;
   logic        load_n = 1'b1;
   logic        clr_n = 1'b1;
   logic        mid_sel = 1'b0;
   logic        sdo;
   logic [55:0] dac_code;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   quad_dac_regif i_quad_dac_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .sdi      (sdi),
      .load_n   (load_n),
      .clr_n    (clr_n),
      .mid_sel  (mid_sel),
      .sdo      (sdo),
      .dac_code (dac_code)
   );

   function automatic int chv(input int i);
      return int'(dac_code[i*14 +: 14]);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference, compared on every clock
   bit sent[$];
   int m_in[4];
   int m_dac[4];
   bit m_sdo, m_sq, m_cq;

   always @(posedge clk) begin
      if (!rst_n) begin
         sent = {};
         repeat (17) sent.push_back(1'b0);
         foreach (m_in[i]) begin m_in[i] = 0; m_dac[i] = 0; end
         m_sdo = 0; m_sq = 0; m_cq = 1;
      end else begin
         int fv;
         fv = mid_sel ? 'h2000 : 0;
         for (int i = 0; i < 4; i++) begin
            if (!clr_n) m_dac[i] = fv;
            else if (!load_n) m_dac[i] = m_in[i];
         end
         if (!clr_n) begin
            for (int i = 0; i < 4; i++) m_in[i] = fv;
         end else if (cs_n && !m_cq) begin
            int w;
            w = 0;
            for (int k = 1; k <= 16; k++) w = (w << 1) | int'(sent[k]);
            m_in[w >> 14] = w & 'h3FFF;
         end
         if (!cs_n && sclk && !m_sq) begin
            sent.push_back(sdi);
            void'(sent.pop_front());
         end
         if (!cs_n && !sclk && m_sq) m_sdo = sent[0];
         m_sq = sclk;
         m_cq = cs_n;
      end
      #1;
      if (!done) begin
         for (int i = 0; i < 4; i++) chk("R5 R6 model dac", chv(i), m_dac[i]);
         chk("R8 R9 model sdo", int'(sdo), int'(m_sdo));
      end
   end

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      cs_n = 1'b0;
      waitn(2);
      for (int b = n - 1; b >= 0; b--) begin
         sdi  = v[b];
         sclk = 1'b0;
         waitn(2);
         sclk = 1'b1;
         waitn(2);
      end
      sclk = 1'b0;
      waitn(2);
      cs_n = 1'b1;
      waitn(2);
   endtask

   task automatic strobe;
      load_n = 1'b0;
      waitn(2);
      load_n = 1'b1;
      waitn(2);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      waitn(3);
      // R7 reset state
      for (int i = 0; i < 4; i++) chk("R7 reset code", chv(i), 0);
      chk("R7 reset sdo", int'(sdo), 0);
      rst_n = 1'b1;
      waitn(2);

      // R1 R2: write channel 0, hold until strobe (R5)
      send({16'b0, 2'd0, 14'h1234}, 16);
      chk("R5 held before strobe", chv(0), 0);
      strobe();
      chk("R1 R2 ch0 written", chv(0), 'h1234);
      chk("R2 ch1 untouched", chv(1), 0);

      send({16'b0, 2'd2, 14'h3FFF}, 16);
      send({16'b0, 2'd3, 14'h0001}, 16);
      send({16'b0, 2'd1, 14'h2AAA}, 16);
      strobe();
      chk("R2 ch1", chv(1), 'h2AAA);
      chk("R2 ch2", chv(2), 'h3FFF);
      chk("R2 ch3", chv(3), 'h0001);

      // R3: 20-bit frame, leading four bits dropped
      send({12'b0, 4'hF, 2'd1, 14'h0155}, 20);
      strobe();
      chk("R3 last 16 bits", chv(1), 'h0155);
      chk("R3 ch3 unchanged", chv(3), 'h0001);

      // R4: clock toggles with select high do not shift
      sdi = 1'b1;
      for (int t = 0; t < 8; t++) begin
         sclk = ~sclk;
         waitn(2);
      end
      sclk = 1'b0;
      waitn(1);
      cs_n = 1'b0;
      waitn(2);
      cs_n = 1'b1;
      waitn(2);
      strobe();
      chk("R4 word kept ch1", chv(1), 'h0155);
      chk("R4 word kept ch3", chv(3), 'h0001);

      // R5: transfer input held low makes the second stage follow
      load_n = 1'b0;
      send({16'b0, 2'd2, 14'h0ABC}, 16);
      chk("R5 transparent", chv(2), 'h0ABC);

      // R6: clear to half-scale, wins over a frame end
      mid_sel = 1'b1;
      clr_n   = 1'b0;
      send({16'b0, 2'd0, 14'h0777}, 16);
      for (int i = 0; i < 4; i++) chk("R6 half-scale", chv(i), 'h2000);
      clr_n = 1'b1;
      waitn(3);
      chk("R6 stage also cleared", chv(0), 'h2000);
      mid_sel = 1'b0;
      clr_n   = 1'b0;
      waitn(2);
      clr_n = 1'b1;
      waitn(2);
      for (int i = 0; i < 4; i++) chk("R6 zero code", chv(i), 0);
      load_n = 1'b1;

      // R7: asynchronous reset after a write
      send({16'b0, 2'd3, 14'h1111}, 16);
      strobe();
      @(negedge clk);
      rst_n = 1'b0;
      #0.5;
      chk("R7 async clear", chv(3), 0);
      waitn(2);
      rst_n = 1'b1;
      waitn(2);

      // R8: one then sixteen zeros, sample sdo after each falling edge
      cs_n = 1'b0;
      waitn(2);
      for (int k = 1; k <= 17; k++) begin
         sdi  = (k == 1);
         sclk = 1'b1;
         waitn(2);
         sclk = 1'b0;
         waitn(2);
         chk("R8 chain delay", int'(sdo), (k == 17) ? 1 : 0);
      end
      cs_n = 1'b1;
      waitn(2);
      // R9: select high, falling edges leave sdo
      sclk = 1'b1; waitn(2); sclk = 1'b0; waitn(2);
      chk("R9 sdo held", int'(sdo), 1);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule